// File: doc/BRIEF.md
# Iterative Round Cipher Block Encryptor

This block encrypts one 2W-bit data block with a round function built from three word operations: bitwise XOR, left rotation by an amount taken from the other word, and addition modulo 2^W. The block is split into a high word and a low word. Both words first receive an initial key addition. After that, R rounds run, and each round mixes the two words with a pair of round keys. One round completes on every clock edge. The initial addition uses the edge that accepts the block, so a block needs R+1 clock edges in total.

Round keys are loaded before any encryption through a narrow write port. Each write carries a key index and a W-bit value. Bit 0 of the index selects one of two key banks: the even bank or the odd bank. The remaining index bits give the word address inside that bank. Each bank is read at one address per cycle, which lets the even and odd keys of a round be fetched together. Encryption starts by itself when a message word is written while the block is idle. When the last round finishes, the ciphertext output updates and a one-cycle completion strobe is raised. The ciphertext output keeps its value until the next completion.

Top module: `rc5_iter_enc`

## Requirements
- R1: A key write with `key_we` high stores `key_data` at index `key_idx`. Bit 0 of the index selects the bank (0 = even keys S[2j], 1 = odd keys S[2j+1]), and bits [IDXW-1:1] give the address j. A write whose index is 2R+2 or above changes no key.
- R2: On the edge that accepts a block, the high word becomes msg[2W-1:W] + S[0] and the low word becomes msg[W-1:0] + S[1], both modulo 2^W.
- R3: Round j (1..R) computes hi' = rotl(hi ^ lo, lo) + S[2j], then lo' = rotl(lo ^ hi', hi') + S[2j+1]. The new high word hi' is used in the low-word update of the same round.
- R4: Each rotation amount uses only the low log2(W) bits of the controlling word. The upper bits of that word have no effect on the amount.
- R5: `msg_we` sampled high while idle starts an encryption. `done` is high in the cycle that follows the R-th rising edge after the accepting edge.
- R6: `done` is a single-cycle pulse for each completed block.
- R7: After reset, `ctext` reads zero and `done` is low until the first encryption completes.
- R8: `ctext` changes only in a cycle in which `done` is high. Between completions it holds the last ciphertext.
- R9: A `msg_we` that arrives while an encryption is in progress is ignored. It does not change the result, the timing, or the number of `done` pulses.
- R10: The ciphertext is the final high word in `ctext[2W-1:W]`, concatenated with the final low word in `ctext[W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_we | input | 1 | Round key write strobe |
| key_idx | input | IDXW | Round key index; bit 0 selects the bank |
| key_data | input | W | Round key value |
| msg_we | input | 1 | Message write strobe; starts an encryption when idle |
| msg | input | 2W | Plaintext block, high word first |
| done | output | 1 | One-cycle completion strobe |
| ctext | output | 2W | Last completed ciphertext |

## Verification
The bench builds the block with W=32 and R=5. A 32-bit word needs five rotation-amount bits, so test words with set upper bits show whether the amount is masked correctly. With R=5 there are 12 keys, which does not fill the 4-bit index space. Indices 12 to 15 therefore exist on the port and can be written, which tests that out-of-range key writes are ignored. The five rounds also leave enough cycles to place a second message write in the middle of an encryption.

// File: rtl/rc5it_pkg.sv
package rc5it_pkg;
  typedef enum logic { PH_IDLE = 1'b0, PH_RUN = 1'b1 } rc5it_phase_e;
endpackage

// File: rtl/rc5it_keybank.sv
module rc5it_keybank #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int WAW   = 2
) (
  input  logic           clk,
  input  logic           we,
  input  logic [WAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [AW-1:0]  raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];
  logic         addr_ok;

  assign addr_ok = (int'(waddr) < DEPTH);

  always_ff @(posedge clk) begin
    if (we && addr_ok) mem[waddr[AW-1:0]] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rc5it_mix.sv
module rc5it_mix #(
  parameter int W = 16
) (
  input  logic         init,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] k_even,
  input  logic [W-1:0] k_odd,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx
);
  localparam int LGW = $clog2(W);

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input logic [LGW-1:0] amt);
    logic [2*W-1:0] dbl;
    dbl = {x, x} << amt;
    return dbl[2*W-1:W];
  endfunction

  function automatic logic [W-1:0] mix(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic [W-1:0] k);
    return rotl(x ^ y, y[LGW-1:0]) + k;
  endfunction

  logic [W-1:0] hi_rnd;

  always_comb begin
    hi_rnd = mix(hi, lo, k_even);
    if (init) begin
      hi_nx = hi + k_even;
      lo_nx = lo + k_odd;
    end else begin
      hi_nx = hi_rnd;
      lo_nx = mix(lo, hi_rnd, k_odd);
    end
  end
endmodule

// File: rtl/rc5it_ctrl.sv
module rc5it_ctrl
  import rc5it_pkg::*;
#(
  parameter int R  = 3,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          msg_we,
  output logic          start,
  output logic          last,
  output logic          busy,
  output logic [AW-1:0] rnd,
  output logic          done
);
  rc5it_phase_e phase;

  assign busy  = (phase == PH_RUN);
  assign start = !busy && msg_we;
  assign last  = busy && (rnd == AW'(R));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      rnd   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        phase <= PH_RUN;
        rnd   <= AW'(1);
      end else if (last) begin
        phase <= PH_IDLE;
        rnd   <= '0;
      end else if (busy) begin
        rnd <= rnd + AW'(1);
      end
    end
  end

  p_start_r5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && rnd == AW'(1));
  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    busy && !last |=> busy && rnd == $past(rnd) + AW'(1));
  p_finish_r5: assert property (@(posedge clk) disable iff (rst)
    last |=> done && !busy);
  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rc5_iter_enc.sv
module rc5_iter_enc #(
  parameter int W    = 16,
  parameter int R    = 3,
  parameter int IDXW = $clog2(2*R+2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            key_we,
  input  logic [IDXW-1:0] key_idx,
  input  logic [W-1:0]    key_data,
  input  logic            msg_we,
  input  logic [2*W-1:0]  msg,
  output logic            done,
  output logic [2*W-1:0]  ctext
);
  localparam int DEPTH = R + 1;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int WAW   = (IDXW > 1) ? IDXW - 1 : 1;

  logic          start, last, busy;
  logic [AW-1:0] rnd, rd_addr;
  logic [W-1:0]  bank_rd [2];
  logic [W-1:0]  hi_q, lo_q, hi_in, lo_in, hi_nx, lo_nx;
  logic [WAW-1:0] wr_addr;

  assign wr_addr = WAW'(key_idx >> 1);
  assign rd_addr = busy ? rnd : '0;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    rc5it_keybank #(.W(W), .DEPTH(DEPTH), .AW(AW), .WAW(WAW)) u_bank (
      .clk   (clk),
      .we    (key_we && (key_idx[0] == 1'(g))),
      .waddr (wr_addr),
      .wdata (key_data),
      .raddr (rd_addr),
      .rdata (bank_rd[g])
    );
  end

  rc5it_ctrl #(.R(R), .AW(AW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .msg_we (msg_we),
    .start  (start),
    .last   (last),
    .busy   (busy),
    .rnd    (rnd),
    .done   (done)
  );

  assign hi_in = start ? msg[2*W-1:W] : hi_q;
  assign lo_in = start ? msg[W-1:0]   : lo_q;

  rc5it_mix #(.W(W)) u_mix (
    .init   (start),
    .hi     (hi_in),
    .lo     (lo_in),
    .k_even (bank_rd[0]),
    .k_odd  (bank_rd[1]),
    .hi_nx  (hi_nx),
    .lo_nx  (lo_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ctext <= '0;
    end else begin
      if (start || busy) begin
        hi_q <= hi_nx;
        lo_q <= lo_nx;
      end
      if (last) ctext <= {hi_nx, lo_nx};
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ctext));
  p_words_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> ctext == {hi_q, lo_q});
endmodule

// File: tb/tb_rc5_iter_enc.sv
module tb_rc5_iter_enc;
  localparam int BW = 32;
  localparam int BR = 5;
  localparam int NK = 2*BR + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          key_we = 1'b0;
  logic [3:0]    key_idx = '0;
  logic [BW-1:0] key_data = '0;
  logic          msg_we = 1'b0;
  logic [63:0]   msg = '0;
  logic          done;
  logic [63:0]   ctext;

  int total = 0;
  int bad = 0;
  logic [31:0] keys [NK];
  logic [63:0] last_ct = '0;

  always #5 clk = ~clk;

  rc5_iter_enc #(.W(BW), .R(BR)) dut (
    .clk(clk), .rst(rst), .key_we(key_we), .key_idx(key_idx), .key_data(key_data),
    .msg_we(msg_we), .msg(msg), .done(done), .ctext(ctext)
  );

  function automatic logic [31:0] rot32(input logic [31:0] x, input logic [4:0] s);
    logic [31:0] r;
    r = x;
    for (int i = 0; i < 32; i++) if (i < int'(s)) r = {r[30:0], r[31]};
    return r;
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] m);
    logic [31:0] a, b;
    a = m[63:32] + keys[0];
    b = m[31:0] + keys[1];
    for (int j = 1; j <= BR; j++) begin
      a = rot32(a ^ b, b[4:0]) + keys[2*j];
      b = rot32(b ^ a, a[4:0]) + keys[2*j+1];
    end
    return {a, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_key(input int idx, input logic [31:0] v);
    @(negedge clk);
    key_we = 1'b1; key_idx = 4'(idx); key_data = v;
    @(negedge clk);
    key_we = 1'b0;
    if (idx < NK) keys[idx] = v;
  endtask

  // Starts an encryption; optionally writes a second message mid-run (R9).
  task automatic run_enc(input string tag, input logic [63:0] m, input bit poke);
    int edges;
    int pulses;
    logic [63:0] exp;
    exp = ref_enc(m);
    @(negedge clk);
    msg_we = 1'b1; msg = m;
    @(posedge clk);
    @(negedge clk);
    msg_we = 1'b0;
    edges = 0;
    pulses = 0;
    while (!done && edges < 3*BR) begin
      check({tag, " R8 hold"}, ctext, last_ct);
      if (poke && edges == 1) begin msg_we = 1'b1; msg = ~m; end
      @(posedge clk);
      @(negedge clk);
      msg_we = 1'b0;
      edges++;
    end
    check({tag, " R5 latency"}, 64'(edges), 64'(BR));
    check({tag, " R2 R3 R10 ctext"}, ctext, exp);
    last_ct = exp;
    for (int k = 0; k < BR + 2; k++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    check({tag, " R6 R9 single pulse"}, 64'(pulses), 64'd1);
    check({tag, " R8 hold after"}, ctext, last_ct);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7 ctext zero", ctext, 64'd0);
    check("R7 done low", 64'(done), 64'd0);
  endtask

  task automatic t_load;
    for (int i = 0; i < NK; i++) put_key(i, 32'h9E3779B9 * (i + 3) + 32'h0F1E2D3C);
    @(negedge clk);
    check("R7 zero after key load", ctext, 64'd0);
  endtask

  task automatic t_basic;
    run_enc("basic", 64'h0123456789ABCDEF, 1'b0);
    run_enc("zero msg", 64'd0, 1'b0);
  endtask

  task automatic t_rot_mask;
    run_enc("R4 mask high", 64'hFFFFFFE3_7FFFFFFF, 1'b0);
    run_enc("R4 mask low", 64'h0000001F_FFFFFFE0, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run_enc("R9 mid write", 64'hDEADBEEF_CAFEF00D, 1'b1);
  endtask

  task automatic t_key_rewrite;
    put_key(2*BR + 1, 32'h13572468);
    put_key(4, 32'hA5A5A5A5);
    run_enc("R1 rewrite", 64'h55AA33CC_0F0FF0F0, 1'b0);
    for (int i = NK; i < 16; i++) put_key(i, 32'hFFFF0000 + i);
    run_enc("R1 out of range", 64'h55AA33CC_0F0FF0F0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_basic();
    t_rot_mask();
    t_busy_ignore();
    t_key_rewrite();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule